// File: doc/BRIEF.md
# Write-Once Fuse Line Array

This block models a one-time-programmable fuse array built from flops. It holds a parameterised number of lines (50 by default). Each line has 64 data bits and a validity bit. A simple 32-bit register bus reaches each line through three word registers. Software first stages the low and high data words, then sets the validity bit. That commit copies the staged words into the permanent cells and locks the line for good. Of the high word, only bits 55:32 carry payload and bit 56 is a format flag, so the high register keeps 25 bits.

A control register at a fixed offset holds a global program-enable bit, which gates every line write. It also shows a burn-busy flag and a sticky error flag. A commit starts a fixed burn time, set by a parameter as a cycle count. During that time further line writes are refused. A refused write (line locked, program enable clear, or burn in progress) changes nothing and sets the error flag. Reset clears the staged words, the control register and the error flag, but the committed cells survive it.

The burn sequencer has two named states. In `ST_IDLE`, line writes are accepted. An accepted commit takes the transition *commit* to `ST_BURN`, where a down-counter runs for `BURN_CYCLES` cycles. The transition *burn done*, taken when the counter reaches zero, returns it to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `fuse_line_array`

## Requirements
- R1: After reset the control register reads 0 (program enable 0, error 0, busy 0), and every unlocked line reads 0 in all three registers.
- R2: Line n is reached at byte offsets 16n (data bits 31:0), 16n+4 (data bits 63:32) and 16n+8 (validity in bit 0). The control register sits at offset 0x400, with program enable in bit 31 (read/write), the sticky error flag in bit 1 and busy in bit 0.
- R3: A write to the low register of an unlocked line is stored whole and reads back. A write to the high register keeps only write-data bits 24:0 (fuse bits 56:32), and bits 31:25 read as 0.
- R4: Writing 1 to bit 0 of a line's validity register, while program enable is set, the block is not busy and the line is unlocked, commits the staged words. From then on the validity register reads 1 and the data registers read the committed values.
- R5: Any write to a committed line's three registers leaves its readback unchanged and sets the error flag.
- R6: While program enable is 0, line writes are ignored and set the error flag.
- R7: Busy rises in the cycle after the commit write and stays high for exactly `BURN_CYCLES` cycles. Line writes made while busy are dropped and set the error flag.
- R8: The error flag stays set once set, until reset.
- R9: Reset keeps committed lines, including data and validity, and clears the staged words of unlocked lines.
- R10: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read.
- R11: Writing 0 to bit 0 of a validity register commits nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| burn_busy | output | 1 | High during the burn time |
| wr_error | output | 1 | Sticky refused-write flag |

## Verification
A write takes effect at the clock edge on which it is presented. Staged data, lock state, error flag and busy all change at that edge. Read data is registered and lands one edge after the read request. The bench drives each access on a falling edge and releases it on the next falling edge, so the single rising edge in between performs the access, and it samples every output at that second falling edge. Busy is sampled on each falling edge after the commit edge, and the number of high samples must equal `BURN_CYCLES`.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BURN = 1'b1
    } burn_state_e;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_VLD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int unsigned BUS_W     = 32;
    localparam int unsigned HI_KEEP_W = 25;
    localparam int unsigned LINE_BYTE_SHIFT = 4;
endpackage

// File: rtl/fuse_addr_decode.sv
module fuse_addr_decode
    import fuse_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_LINES = 50,
    parameter int unsigned IDX_W     = $clog2(NUM_LINES),
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h400
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              line_hit,
    output logic              ctrl_hit,
    output logic [IDX_W-1:0]  line_idx,
    output reg_sel_e          sel
);
    localparam int unsigned FIELD_W = ADDR_W - LINE_BYTE_SHIFT;

    logic [FIELD_W-1:0] field;

    always_comb begin
        field    = addr[ADDR_W-1:LINE_BYTE_SHIFT];
        line_idx = field[IDX_W-1:0];
        ctrl_hit = (addr[ADDR_W-1:2] == CTRL_ADDR[ADDR_W-1:2]);
        unique case (addr[3:2])
            2'd0:    sel = SEL_LO;
            2'd1:    sel = SEL_HI;
            2'd2:    sel = SEL_VLD;
            default: sel = SEL_NONE;
        endcase
        line_hit = (32'(field) < NUM_LINES) && (sel != SEL_NONE) && !ctrl_hit;
    end
endmodule

// File: rtl/fuse_burn_timer.sv
module fuse_burn_timer
    import fuse_pkg::*;
#(
    parameter int unsigned BURN_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(BURN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURN_CYCLES - 1);

    burn_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_BURN;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_BURN: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_BURN: busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assert_busy_after_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_count_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= CNT_LOAD));

    assert_idle_count_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/fuse_line_store.sv
module fuse_line_store
    import fuse_pkg::*;
#(
    parameter int unsigned NUM_LINES = 50,
    parameter int unsigned IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stage_we,
    input  logic                 stage_hi,
    input  logic                 commit,
    input  logic [IDX_W-1:0]     idx,
    input  logic [BUS_W-1:0]     wdata,
    output logic [BUS_W-1:0]     rd_lo,
    output logic [HI_KEEP_W-1:0] rd_hi,
    output logic                 rd_locked,
    output logic [NUM_LINES-1:0] locked_vec
);
    localparam int unsigned DATA_W = BUS_W + HI_KEEP_W;

    logic [DATA_W-1:0]    stage_q [NUM_LINES];
    logic [DATA_W-1:0]    cell_q  [NUM_LINES] = '{default: '0};
    logic [NUM_LINES-1:0] vld_q = '0;
    logic [DATA_W-1:0]    view;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                stage_q[i] <= '0;
            end
        end else if (stage_we) begin
            if (stage_hi) begin
                stage_q[idx][DATA_W-1:BUS_W] <= wdata[HI_KEEP_W-1:0];
            end else begin
                stage_q[idx][BUS_W-1:0] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && commit) begin
            cell_q[idx] <= stage_q[idx];
            vld_q[idx]  <= 1'b1;
        end
    end

    always_comb begin
        rd_locked  = vld_q[idx];
        view       = rd_locked ? cell_q[idx] : stage_q[idx];
        rd_lo      = view[BUS_W-1:0];
        rd_hi      = view[DATA_W-1:BUS_W];
        locked_vec = vld_q;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_lock_chk
        assert_locked_line_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[g] |=> (vld_q[g] && $stable(cell_q[g])));
    end
endmodule

// File: rtl/fuse_line_array.sv
module fuse_line_array
    import fuse_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 50,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned BURN_CYCLES = 1000000,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              burn_busy,
    output logic              wr_error
);
    localparam int unsigned IDX_W = $clog2(NUM_LINES);

    logic                 line_hit, ctrl_hit;
    logic [IDX_W-1:0]     line_idx;
    reg_sel_e             sel;
    logic                 prog_en_q, err_q;
    logic [31:0]          rdata_q, rd_mux;
    logic                 line_wr, blocked, stage_we, commit, err_set;
    logic [31:0]          rd_lo;
    logic [HI_KEEP_W-1:0] rd_hi;
    logic                 rd_locked;
    logic [NUM_LINES-1:0] locked_vec;

    fuse_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .addr(bus_addr), .line_hit(line_hit), .ctrl_hit(ctrl_hit),
        .line_idx(line_idx), .sel(sel)
    );

    fuse_burn_timer #(.BURN_CYCLES(BURN_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(burn_busy)
    );

    fuse_line_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_hi(sel == SEL_HI),
        .commit(commit), .idx(line_idx), .wdata(bus_wdata),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_locked(rd_locked), .locked_vec(locked_vec)
    );

    always_comb begin
        line_wr  = bus_en && bus_we && line_hit;
        blocked  = !prog_en_q || burn_busy || rd_locked;
        stage_we = line_wr && !blocked && (sel != SEL_VLD);
        commit   = line_wr && !blocked && (sel == SEL_VLD) && bus_wdata[0];
        err_set  = line_wr && blocked;
    end

    always_comb begin
        rd_mux = '0;
        if (ctrl_hit) begin
            rd_mux = {prog_en_q, 29'b0, err_q, burn_busy};
        end else if (line_hit) begin
            unique case (sel)
                SEL_LO:  rd_mux = rd_lo;
                SEL_HI:  rd_mux = {{(32 - HI_KEEP_W){1'b0}}, rd_hi};
                SEL_VLD: rd_mux = {31'b0, rd_locked};
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_en_q <= 1'b0;
            err_q     <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (bus_en && bus_we && ctrl_hit) begin
                prog_en_q <= bus_wdata[31];
            end
            if (err_set) begin
                err_q <= 1'b1;
            end
            if (bus_en && !bus_we) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign wr_error  = err_q;

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_error |=> wr_error);

    assert_no_burn_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en_q |=> $stable(locked_vec));

    assert_one_line_per_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(locked_vec) <= $countones($past(locked_vec)) + 1);

    assert_busy_holds_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (burn_busy && $past(burn_busy)) |-> $stable(locked_vec));
endmodule

// File: tb/fuse_line_array_test.sv
`timescale 1ns/1ps
module fuse_line_array_test;
    localparam int BURN = 40;
    localparam logic [11:0] CTRL = 12'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        burn_busy;
    logic        wr_error;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    fuse_line_array #(.BURN_CYCLES(BURN)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .burn_busy(burn_busy), .wr_error(wr_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk); bus_en = 1'b0; d = bus_rdata;
    endtask

    function automatic logic [11:0] la(input int line, input int r);
        return 12'(line * 16 + r * 4);
    endfunction

    task automatic wait_idle();
        while (burn_busy) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(CTRL, v);     check("R1 ctrl after reset", v, 32'h0);
        rd(la(10, 0), v); check("R1 lo after reset", v, 32'h0);
        rd(la(10, 2), v); check("R1 vld after reset", v, 32'h0);
    endtask

    task automatic t_stage();
        logic [31:0] v;
        do_reset();
        wr(CTRL, 32'h8000_0000);
        rd(CTRL, v); check("R2 prog enable bit31", v, 32'h8000_0000);
        wr(la(3, 0), 32'hDEAD_BEEF);
        wr(la(3, 1), 32'hFFFF_FFFF);
        rd(la(3, 0), v); check("R3 lo staged", v, 32'hDEAD_BEEF);
        rd(la(3, 1), v); check("R3 hi keeps 25 bits", v, 32'h01FF_FFFF);
        rd(la(3, 2), v); check("R2 vld unlocked", v, 32'h0);
        check("R3 no error", {31'b0, wr_error}, 32'h0);
    endtask

    task automatic t_commit();
        logic [31:0] v;
        int n;
        do_reset();
        wr(CTRL, 32'h8000_0000);
        wr(la(0, 0), 32'hA5A5_0001);
        wr(la(0, 1), 32'h01AB_CDEF);
        wr(la(0, 2), 32'h1);
        check("R7 busy next cycle", {31'b0, burn_busy}, 32'h1);
        n = 0;
        while (burn_busy) begin n++; @(negedge clk); end
        check("R7 busy length", 32'(n), 32'(BURN));
        rd(la(0, 2), v); check("R4 vld reads 1", v, 32'h1);
        rd(la(0, 0), v); check("R4 lo committed", v, 32'hA5A5_0001);
        rd(la(0, 1), v); check("R4 hi committed", v, 32'h01AB_CDEF);
        check("R4 no error", {31'b0, wr_error}, 32'h0);
    endtask

    task automatic t_locked();
        logic [31:0] v;
        do_reset();
        wr(CTRL, 32'h8000_0000);
        wr(la(49, 0), 32'h1234_5678);
        wr(la(49, 2), 32'h1);
        wait_idle();
        wr(la(49, 0), 32'hFFFF_FFFF);
        check("R5 error on locked write", {31'b0, wr_error}, 32'h1);
        wr(la(49, 1), 32'h0000_00FF);
        rd(la(49, 0), v); check("R5 lo unchanged", v, 32'h1234_5678);
        rd(la(49, 1), v); check("R5 hi unchanged", v, 32'h0);
        rd(CTRL, v); check("R8 error sticky in ctrl", v, 32'h8000_0002);
        wr(CTRL, 32'h0);
        check("R8 error survives ctrl write", {31'b0, wr_error}, 32'h1);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        do_reset();
        wr(la(7, 0), 32'h5555_AAAA);
        check("R6 error when disabled", {31'b0, wr_error}, 32'h1);
        rd(la(7, 0), v); check("R6 lo ignored", v, 32'h0);
        wr(la(7, 2), 32'h1);
        check("R6 no busy when disabled", {31'b0, burn_busy}, 32'h0);
        rd(la(7, 2), v); check("R6 vld ignored", v, 32'h0);
    endtask

    task automatic t_busy_drop();
        logic [31:0] v;
        do_reset();
        wr(CTRL, 32'h8000_0000);
        wr(la(2, 2), 32'h1);
        wr(la(4, 0), 32'hCAFE_F00D);
        check("R7 error when busy", {31'b0, wr_error}, 32'h1);
        rd(CTRL, v); check("R7 busy in ctrl bit0", v, 32'h8000_0003);
        wait_idle();
        rd(la(4, 0), v); check("R7 write dropped", v, 32'h0);
    endtask

    task automatic t_zero_valid();
        logic [31:0] v;
        do_reset();
        wr(CTRL, 32'h8000_0000);
        wr(la(6, 0), 32'h0000_0042);
        wr(la(6, 2), 32'hFFFF_FFFE);
        check("R11 no busy", {31'b0, burn_busy}, 32'h0);
        check("R11 no error", {31'b0, wr_error}, 32'h0);
        rd(la(6, 2), v); check("R11 still unlocked", v, 32'h0);
        wr(la(6, 0), 32'h0000_0043);
        rd(la(6, 0), v); check("R11 still writable", v, 32'h0000_0043);
    endtask

    task automatic t_persist();
        logic [31:0] v;
        do_reset();
        wr(CTRL, 32'h8000_0000);
        wr(la(5, 0), 32'h0BAD_F00D);
        wr(la(5, 1), 32'h0100_0001);
        wr(la(5, 2), 32'h1);
        wait_idle();
        wr(la(8, 0), 32'h7777_7777);
        do_reset();
        rd(la(5, 0), v); check("R9 lo persists", v, 32'h0BAD_F00D);
        rd(la(5, 1), v); check("R9 hi persists", v, 32'h0100_0001);
        rd(la(5, 2), v); check("R9 vld persists", v, 32'h1);
        rd(la(8, 0), v); check("R9 staged cleared", v, 32'h0);
    endtask

    task automatic t_read_latency();
        do_reset();
        wr(CTRL, 32'h8000_0000);
        @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = CTRL;
        check("R10 old data before edge", bus_rdata, 32'h0);
        @(negedge clk); bus_en = 1'b0;
        check("R10 data after one edge", bus_rdata, 32'h8000_0000);
        @(negedge clk);
        check("R10 data holds", bus_rdata, 32'h8000_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_stage();
        t_commit();
        t_locked();
        t_disabled();
        t_busy_drop();
        t_zero_valid();
        t_persist();
        t_read_latency();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule